// File: doc/BRIEF.md
# Receive Frame Checker and Filter

This block sits on the receive side of a 10 Gb/s Ethernet MAC, downstream of the line decoder. It takes frames as a stream of 64-bit beats. Each beat carries eight byte lanes, a byte-enable mask, start and end markers, and an FCS-error flag on the last beat. The first byte on the wire travels in bits [7:0]. The FCS bytes are part of the stream and are counted in the frame length.

In one pass over the frame, the block does three things:
- It reads the destination address from the first beat and decides whether the frame passes the address filter.
- It counts bytes and reads the type/length field, stepping over a VLAN tag when one is present.
- At the final beat it judges the frame length.

A frame that passes the filter comes out on an AXI4-Stream master port one cycle after each input beat, with unchanged data. Any length or FCS problem is flagged in `tuser` on the last beat. A frame that fails the filter produces no output beats at all.

For every frame, accepted or dropped, one status word is emitted alongside the last output slot.

The input has no ready signal, so the output port has none either. The consumer must accept a beat in every cycle. Configuration inputs are expected to stay constant while a frame is in flight. Reset is asynchronous and active low, and is released in step with `clk`.

Top module: `rxf_frame_checker`

## Requirements
- R1: While reset is asserted and after its release with no input, `m_tvalid` and `st_valid` are low.
- R2: Each beat of an accepted frame appears on `m_tdata`/`m_tkeep` one clock after it was presented, unchanged. `m_tlast` marks the beat that carried `in_eof`.
- R3: A beat with `in_valid` high outside a frame (no `in_sof` seen since the last `in_eof`) produces no output beat and no status.
- R4: A destination address of 48'hFFFF_FFFF_FFFF is broadcast. It bypasses the address match. When `cfg_bcast_reject` is 1 the whole frame is dropped and `st_drop_bcast` is set; when it is 0 the frame is forwarded.
- R5: The destination address is frame bytes 0..5, with byte 0 as its most significant byte. A unicast frame (bit 0 of byte 0 clear) passes when ((DA ^ `cfg_ucast_addr`) & `cfg_ucast_mask`) is zero. Otherwise it is dropped whole with `st_drop_addr` set. With `cfg_filter_en` at 0 no address drop occurs.
- R6: A multicast frame (bit 0 of byte 0 set, not broadcast) is matched the same way against `cfg_mcast_addr` under `cfg_mcast_mask`.
- R7: A frame whose byte count, including FCS, exceeds `cfg_mtu` is oversized. It sets `st_oversize` and `m_tuser` on the last beat.
- R8: Payload is the byte count minus 18 (minus 22 with a VLAN tag). A payload below 46 bytes is undersized. It sets `st_undersize` and `m_tuser`.
- R9: The type/length field is read from bytes 12..13, most significant byte first. If it is 0x8100, the field is read from bytes 16..17 instead.
  - A value of 1500 or less is a length. The frame is flagged as a mismatch (`st_len_err`, `m_tuser`) when the payload differs from the larger of that value and 46.
  - A value above 1500 is not checked.
- R10: `in_fcs_err` on the last beat sets `st_fcs_err` and `m_tuser`.
- R11: One clock after each frame's last beat, `st_valid` pulses once with that frame's flags. This happens for dropped frames too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_data | input | 64 | Input bytes, first byte in [7:0] |
| in_keep | input | 8 | Input byte enables, contiguous from lane 0 |
| in_sof | input | 1 | First beat of a frame |
| in_eof | input | 1 | Last beat of a frame |
| in_fcs_err | input | 1 | FCS failed, valid with `in_eof` |
| cfg_mtu | input | 14 | Largest good frame length in bytes |
| cfg_filter_en | input | 1 | Enable destination address matching |
| cfg_bcast_reject | input | 1 | Drop broadcast frames |
| cfg_ucast_addr | input | 48 | Unicast reference address |
| cfg_ucast_mask | input | 48 | Unicast compare mask, 1 = bit compared |
| cfg_mcast_addr | input | 48 | Multicast reference address |
| cfg_mcast_mask | input | 48 | Multicast compare mask, 1 = bit compared |
| m_tvalid | output | 1 | Output beat valid |
| m_tdata | output | 64 | Output bytes |
| m_tkeep | output | 8 | Output byte enables |
| m_tlast | output | 1 | Last beat of frame |
| m_tuser | output | 1 | Frame error, meaningful on the last beat |
| st_valid | output | 1 | Per-frame status strobe |
| st_oversize | output | 1 | Frame longer than `cfg_mtu` |
| st_undersize | output | 1 | Payload below 46 bytes |
| st_len_err | output | 1 | Length field disagrees with payload |
| st_fcs_err | output | 1 | FCS error reported on input |
| st_drop_addr | output | 1 | Dropped by address match |
| st_drop_bcast | output | 1 | Dropped as broadcast |

## Verification
A corrupted frame-open flag shows at the ports on the very next beat. Either a stray beat is forwarded or a real frame loses its body, and the status strobe goes missing or doubles. A wrong latched drop decision makes the beats after the first appear or vanish, one clock after they enter. A fault in the byte counter, the VLAN flag or the captured length field stays hidden until the last beat. It then shows one clock later as a wrong `m_tuser` and wrong status flags, so the tests place frame lengths exactly on and one byte past each threshold.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
  localparam int ETH_MIN_PAYLOAD = 46;
  localparam int HDR_PLAIN       = 18;   // DA + SA + type/length + FCS
  localparam int VLAN_EXTRA      = 4;
  localparam int LEN_FIELD_MAX   = 1500;
  localparam int TL_BYTE         = 12;   // type/length offset, untagged
  localparam int VL_BYTE         = 16;   // type/length offset, tagged
  localparam logic [15:0] VLAN_TPID = 16'h8100;

  typedef struct packed {
    logic drop_bcast;
    logic drop_addr;
    logic fcs_err;
    logic len_err;
    logic undersize;
    logic oversize;
  } rxf_status_t;
endpackage

// File: rtl/rxf_addr_match.sv
`timescale 1ns/1ps
module rxf_addr_match #(
  parameter int AW = 48
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] ref_addr,
  input  logic [AW-1:0] mask,
  output logic          hit
);
  logic [AW-1:0] diff;

  always_comb begin
    diff = (addr ^ ref_addr) & mask;
    hit  = (diff == '0);
  end
endmodule

// File: rtl/rxf_addr_filter.sv
`timescale 1ns/1ps
module rxf_addr_filter #(
  parameter int AW = 48
) (
  input  logic [AW-1:0] da_raw,          // byte 0 of the frame in [7:0]
  input  logic          cfg_filter_en,
  input  logic          cfg_bcast_reject,
  input  logic [AW-1:0] cfg_ucast_addr,
  input  logic [AW-1:0] cfg_ucast_mask,
  input  logic [AW-1:0] cfg_mcast_addr,
  input  logic [AW-1:0] cfg_mcast_mask,
  output logic          drop_addr,
  output logic          drop_bcast
);
  localparam int NB   = AW / 8;
  localparam int NREF = 2;               // 0 = unicast, 1 = multicast

  logic [AW-1:0] da;
  logic [AW-1:0] ref_a [NREF];
  logic [AW-1:0] msk_a [NREF];
  logic [NREF-1:0] hit;
  logic is_bcast;
  logic is_mcast;

  // first byte on the wire becomes the most significant address byte
  for (genvar g = 0; g < NB; g++) begin : g_swap
    assign da[AW-1-8*g -: 8] = da_raw[8*g +: 8];
  end

  assign ref_a[0] = cfg_ucast_addr;
  assign msk_a[0] = cfg_ucast_mask;
  assign ref_a[1] = cfg_mcast_addr;
  assign msk_a[1] = cfg_mcast_mask;

  for (genvar r = 0; r < NREF; r++) begin : g_cmp
    rxf_addr_match #(.AW(AW)) u_match (
      .addr     (da),
      .ref_addr (ref_a[r]),
      .mask     (msk_a[r]),
      .hit      (hit[r])
    );
  end

  always_comb begin
    is_bcast   = &da_raw;
    is_mcast   = da_raw[0];
    drop_bcast = is_bcast & cfg_bcast_reject;
    drop_addr  = cfg_filter_en & ~is_bcast & ~hit[is_mcast];
  end
endmodule

// File: rtl/rxf_len_track.sv
`timescale 1ns/1ps
module rxf_len_track
  import rxf_pkg::*;
#(
  parameter int KW    = 8,
  parameter int LEN_W = 15,
  parameter int MTU_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,        // beat belongs to a frame
  input  logic             sof,
  input  logic [KW-1:0]    keep,
  input  logic [15:0]      fld_plain,   // bytes at the untagged field lanes
  input  logic [15:0]      fld_tag,     // bytes at the tagged field lanes
  input  logic [MTU_W-1:0] cfg_mtu,
  output logic             oversize,
  output logic             undersize,
  output logic             len_err
);
  localparam int TL_BEAT = TL_BYTE / KW;
  localparam int TL_OFS  = TL_BYTE % KW;
  localparam int VL_BEAT = VL_BYTE / KW;
  localparam int VL_OFS  = VL_BYTE % KW;
  localparam int IDX_MAX = VL_BEAT + 1;
  localparam int IW      = $clog2(IDX_MAX + 1);
  localparam int CW      = $clog2(KW + 1);

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [15:0]      tl_q, tl_d;
  logic             seen_q, seen_d;
  logic             vlan_q, vlan_d;

  logic [CW-1:0]    nbytes;
  logic [LEN_W-1:0] base;
  logic [LEN_W:0]   sum;
  logic [IW-1:0]    cur_idx;
  logic [LEN_W-1:0] hdr;
  logic [LEN_W-1:0] payload;
  logic [15:0]      exp_pay;

  // byte count of this beat
  always_comb begin
    nbytes = '0;
    for (int i = 0; i < KW; i++) begin
      nbytes = nbytes + CW'(keep[i]);
    end
  end

  // running length and parse position, with saturation
  always_comb begin
    base    = sof ? '0 : cnt_q;
    sum     = {1'b0, base} + (LEN_W+1)'(nbytes);
    cnt_d   = sum[LEN_W] ? '1 : sum[LEN_W-1:0];
    cur_idx = sof ? '0 : idx_q;
    idx_d   = (cur_idx == IW'(IDX_MAX)) ? cur_idx : cur_idx + 1'b1;
  end

  // type/length capture, stepping over one VLAN tag
  always_comb begin
    tl_d   = sof ? '0   : tl_q;
    seen_d = sof ? 1'b0 : seen_q;
    vlan_d = sof ? 1'b0 : vlan_q;
    if (cur_idx == IW'(TL_BEAT) && keep[TL_OFS+1]) begin
      if (fld_plain == VLAN_TPID) begin
        vlan_d = 1'b1;
      end else begin
        tl_d   = fld_plain;
        seen_d = 1'b1;
      end
    end
    if (vlan_d && cur_idx == IW'(VL_BEAT) && keep[VL_OFS+1]) begin
      tl_d   = fld_tag;
      seen_d = 1'b1;
    end
  end

  // end-of-frame judgement, valid in the cycle of the last beat
  always_comb begin
    hdr       = vlan_d ? LEN_W'(HDR_PLAIN + VLAN_EXTRA) : LEN_W'(HDR_PLAIN);
    payload   = (cnt_d >= hdr) ? cnt_d - hdr : '0;
    exp_pay   = (tl_d < 16'(ETH_MIN_PAYLOAD)) ? 16'(ETH_MIN_PAYLOAD) : tl_d;
    oversize  = cnt_d > LEN_W'(cfg_mtu);
    undersize = payload < LEN_W'(ETH_MIN_PAYLOAD);
    len_err   = seen_d && (tl_d <= 16'(LEN_FIELD_MAX)) &&
                (32'(payload) != 32'(exp_pay));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      idx_q  <= '0;
      tl_q   <= '0;
      seen_q <= 1'b0;
      vlan_q <= 1'b0;
    end else if (take) begin
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      tl_q   <= tl_d;
      seen_q <= seen_d;
      vlan_q <= vlan_d;
    end
  end
endmodule

// File: rtl/rxf_frame_checker.sv
`timescale 1ns/1ps
module rxf_frame_checker
  import rxf_pkg::*;
#(
  parameter int DW    = 64,
  parameter int AW    = 48,
  parameter int LEN_W = 15,
  parameter int MTU_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  input  logic [DW/8-1:0]  in_keep,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_fcs_err,
  input  logic [MTU_W-1:0] cfg_mtu,
  input  logic             cfg_filter_en,
  input  logic             cfg_bcast_reject,
  input  logic [AW-1:0]    cfg_ucast_addr,
  input  logic [AW-1:0]    cfg_ucast_mask,
  input  logic [AW-1:0]    cfg_mcast_addr,
  input  logic [AW-1:0]    cfg_mcast_mask,
  output logic             m_tvalid,
  output logic [DW-1:0]    m_tdata,
  output logic [DW/8-1:0]  m_tkeep,
  output logic             m_tlast,
  output logic             m_tuser,
  output logic             st_valid,
  output logic             st_oversize,
  output logic             st_undersize,
  output logic             st_len_err,
  output logic             st_fcs_err,
  output logic             st_drop_addr,
  output logic             st_drop_bcast
);
  localparam int KW     = DW / 8;
  localparam int TL_OFS = TL_BYTE % KW;
  localparam int VL_OFS = VL_BYTE % KW;

  // frame tracking
  logic open_q, open_d;
  logic dra_q, dra_d;                  // latched address drop
  logic drb_q, drb_d;                  // latched broadcast drop
  logic take, fwd, cur_dra, cur_drb;

  // filter and length results
  logic f_dra, f_drb;
  logic l_ovs, l_uns, l_len;
  logic [15:0] fld_plain, fld_tag;

  // output stage
  logic          vld_q, vld_d;
  logic [DW-1:0] dat_q;
  logic [KW-1:0] kep_q;
  logic          lst_q, usr_q, usr_d;
  logic          stv_q, stv_d;
  rxf_status_t   sts_q, sts_d;

  assign fld_plain = {in_data[8*TL_OFS +: 8], in_data[8*(TL_OFS+1) +: 8]};
  assign fld_tag   = {in_data[8*VL_OFS +: 8], in_data[8*(VL_OFS+1) +: 8]};

  rxf_addr_filter #(.AW(AW)) u_filter (
    .da_raw           (in_data[AW-1:0]),
    .cfg_filter_en    (cfg_filter_en),
    .cfg_bcast_reject (cfg_bcast_reject),
    .cfg_ucast_addr   (cfg_ucast_addr),
    .cfg_ucast_mask   (cfg_ucast_mask),
    .cfg_mcast_addr   (cfg_mcast_addr),
    .cfg_mcast_mask   (cfg_mcast_mask),
    .drop_addr        (f_dra),
    .drop_bcast       (f_drb)
  );

  rxf_len_track #(.KW(KW), .LEN_W(LEN_W), .MTU_W(MTU_W)) u_len (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .sof       (in_sof),
    .keep      (in_keep),
    .fld_plain (fld_plain),
    .fld_tag   (fld_tag),
    .cfg_mtu   (cfg_mtu),
    .oversize  (l_ovs),
    .undersize (l_uns),
    .len_err   (l_len)
  );

  // next-state logic
  always_comb begin
    take    = in_valid & (in_sof | open_q);
    open_d  = take ? ~in_eof : open_q;
    cur_dra = in_sof ? f_dra : dra_q;
    cur_drb = in_sof ? f_drb : drb_q;
    dra_d   = (take & in_sof) ? f_dra : dra_q;
    drb_d   = (take & in_sof) ? f_drb : drb_q;
    fwd     = take & ~cur_dra & ~cur_drb;
    vld_d   = fwd;
    usr_d   = in_eof & (l_ovs | l_uns | l_len | in_fcs_err);
    stv_d   = take & in_eof;
    sts_d.drop_bcast = cur_drb;
    sts_d.drop_addr  = cur_dra & ~cur_drb;
    sts_d.fcs_err    = in_fcs_err;
    sts_d.len_err    = l_len;
    sts_d.undersize  = l_uns;
    sts_d.oversize   = l_ovs;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      dra_q  <= 1'b0;
      drb_q  <= 1'b0;
      vld_q  <= 1'b0;
      stv_q  <= 1'b0;
    end else begin
      open_q <= open_d;
      dra_q  <= dra_d;
      drb_q  <= drb_d;
      vld_q  <= vld_d;
      stv_q  <= stv_d;
    end
  end

  // data path registers, enabled by forwarding
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lst_q <= 1'b0;
      usr_q <= 1'b0;
    end else if (fwd) begin
      lst_q <= in_eof;
      usr_q <= usr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fwd) begin
      dat_q <= in_data;
      kep_q <= in_keep;
    end
  end

  // status register, enabled at each frame end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else if (stv_d) begin
      sts_q <= sts_d;
    end
  end

  assign m_tvalid      = vld_q;
  assign m_tdata       = dat_q;
  assign m_tkeep       = kep_q;
  assign m_tlast       = lst_q;
  assign m_tuser       = usr_q;
  assign st_valid      = stv_q;
  assign st_oversize   = sts_q.oversize;
  assign st_undersize  = sts_q.undersize;
  assign st_len_err    = sts_q.len_err;
  assign st_fcs_err    = sts_q.fcs_err;
  assign st_drop_addr  = sts_q.drop_addr;
  assign st_drop_bcast = sts_q.drop_bcast;
endmodule

// File: rtl/rxf_frame_checker_sva.sv
`timescale 1ns/1ps
module rxf_frame_checker_sva #(
  parameter int AW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_sof,
  input logic          in_eof,
  input logic          in_fcs_err,
  input logic [AW-1:0] in_da,
  input logic          cfg_bcast_reject,
  input logic          m_tvalid,
  input logic          st_valid,
  input logic          st_fcs_err
);
  // frame-open state rebuilt from the input ports
  logic chk_open;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_open <= 1'b0;
    else if (in_valid && (in_sof || chk_open)) chk_open <= !in_eof;
  end

  p_fwd_from_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> $past(in_valid));

  p_stray_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sof && !chk_open) |=> (!m_tvalid && !st_valid));

  p_bcast_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && cfg_bcast_reject && (&in_da)) |=> !m_tvalid);

  p_fcs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eof && in_fcs_err && (in_sof || chk_open))
      |=> (st_valid && st_fcs_err));

  p_status_after_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> $past(in_valid && in_eof));
endmodule

bind rxf_frame_checker rxf_frame_checker_sva #(.AW(AW)) u_sva (
  .clk              (clk),
  .rst_n            (rst_n),
  .in_valid         (in_valid),
  .in_sof           (in_sof),
  .in_eof           (in_eof),
  .in_fcs_err       (in_fcs_err),
  .in_da            (in_data[AW-1:0]),
  .cfg_bcast_reject (cfg_bcast_reject),
  .m_tvalid         (m_tvalid),
  .st_valid         (st_valid),
  .st_fcs_err       (st_fcs_err)
);

// File: tb/rxf_frame_checker_tb_top.sv
`timescale 1ns/1ps
module rxf_frame_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sof, in_eof, in_fcs_err;
  logic [63:0] in_data;
  logic [7:0]  in_keep;
  logic [13:0] cfg_mtu;
  logic        cfg_filter_en, cfg_bcast_reject;
  logic [47:0] cfg_ucast_addr, cfg_ucast_mask, cfg_mcast_addr, cfg_mcast_mask;
  logic        m_tvalid, m_tlast, m_tuser;
  logic [63:0] m_tdata;
  logic [7:0]  m_tkeep;
  logic        st_valid, st_oversize, st_undersize, st_len_err;
  logic        st_fcs_err, st_drop_addr, st_drop_bcast;

  always #2.5 clk = ~clk;

  rxf_frame_checker dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_keep(in_keep), .in_sof(in_sof), .in_eof(in_eof), .in_fcs_err(in_fcs_err),
    .cfg_mtu(cfg_mtu), .cfg_filter_en(cfg_filter_en),
    .cfg_bcast_reject(cfg_bcast_reject), .cfg_ucast_addr(cfg_ucast_addr),
    .cfg_ucast_mask(cfg_ucast_mask), .cfg_mcast_addr(cfg_mcast_addr),
    .cfg_mcast_mask(cfg_mcast_mask), .m_tvalid(m_tvalid), .m_tdata(m_tdata),
    .m_tkeep(m_tkeep), .m_tlast(m_tlast), .m_tuser(m_tuser), .st_valid(st_valid),
    .st_oversize(st_oversize), .st_undersize(st_undersize), .st_len_err(st_len_err),
    .st_fcs_err(st_fcs_err), .st_drop_addr(st_drop_addr), .st_drop_bcast(st_drop_bcast)
  );

  int tot = 0;
  int bad = 0;
  bit done = 0;

  // frame image and output capture
  logic [7:0]  fb [0:1023];
  logic [63:0] ob [0:255];
  int          ob_n, last_idx, st_n;
  logic        last_user;
  logic [5:0]  st_flags;   // {bcast, addr, fcs, len, under, over}

  localparam logic [47:0] UC  = 48'h02_11_22_33_44_55;
  localparam logic [47:0] BC  = 48'hFF_FF_FF_FF_FF_FF;

  always @(negedge clk) begin
    if (m_tvalid) begin
      if (ob_n < 256) ob[ob_n] = m_tdata;
      if (m_tlast) begin
        last_idx  = ob_n;
        last_user = m_tuser;
      end
      ob_n++;
    end
    if (st_valid) begin
      st_n++;
      st_flags = {st_drop_bcast, st_drop_addr, st_fcs_err, st_len_err,
                  st_undersize, st_oversize};
    end
  end

  task automatic chk(input string what, input longint act, input longint exp);
    tot++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    in_valid = 0; in_sof = 0; in_eof = 0; in_fcs_err = 0;
    in_data = '0; in_keep = '0;
  endtask

  task automatic build(input logic [47:0] da, input bit vlan,
                       input logic [15:0] tl, input int n);
    for (int i = 0; i < n; i++) fb[i] = 8'(i * 7 + 3);
    for (int k = 0; k < 6; k++) fb[k] = da[47-8*k -: 8];
    for (int k = 6; k < 12; k++) fb[k] = 8'(8'hA0 + k);
    if (vlan) begin
      fb[12] = 8'h81; fb[13] = 8'h00; fb[14] = 8'h00; fb[15] = 8'h05;
      fb[16] = tl[15:8]; fb[17] = tl[7:0];
    end else begin
      fb[12] = tl[15:8]; fb[13] = tl[7:0];
    end
  endtask

  task automatic send(input int n, input bit fcs);
    int nb;
    nb = (n + 7) / 8;
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      in_valid   = 1;
      in_sof     = (b == 0);
      in_eof     = (b == nb - 1);
      in_fcs_err = fcs && (b == nb - 1);
      for (int j = 0; j < 8; j++) begin
        in_data[8*j +: 8] = (8*b + j < n) ? fb[8*b + j] : 8'h00;
        in_keep[j]        = (8*b + j < n);
      end
    end
    @(negedge clk);
    idle_inputs();
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_mon();
    ob_n = 0; st_n = 0; last_idx = -1; last_user = 0; st_flags = '0;
  endtask

  // one frame, all results checked against hand-derived flags
  task automatic run(input string req, input logic [47:0] da, input bit vlan,
                     input logic [15:0] tl, input int n, input bit fcs,
                     input bit exp_fwd, input logic [5:0] exp_flags);
    int nb, mism;
    logic [63:0] e;
    build(da, vlan, tl, n);
    clear_mon();
    send(n, fcs);
    nb = (n + 7) / 8;
    chk({req, " beat count"}, ob_n, exp_fwd ? nb : 0);
    if (exp_fwd) begin
      mism = 0;
      for (int i = 0; i < nb; i++) begin
        for (int j = 0; j < 8; j++) e[8*j +: 8] = (8*i + j < n) ? fb[8*i + j] : 8'h00;
        if (ob[i] !== e) mism++;
      end
      chk({req, " data mismatches"}, mism, 0);
      chk({req, " tlast position"}, last_idx, nb - 1);
      chk({req, " tuser"}, last_user, |exp_flags[3:0]);
    end
    chk({req, " status count"}, st_n, 1);
    chk({req, " status flags"}, st_flags, exp_flags);
  endtask

  task automatic t_reset();
    rst_n = 1;
    idle_inputs();
    cfg_mtu = 14'd1518; cfg_filter_en = 1; cfg_bcast_reject = 0;
    cfg_ucast_addr = UC;                cfg_ucast_mask = 48'hFFFF_FFFF_FF00;
    cfg_mcast_addr = 48'h01_00_5E_00_00_00; cfg_mcast_mask = 48'hFFFF_FF80_0000;
    clear_mon();
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 tvalid in reset", m_tvalid, 0);
    chk("R1 st_valid in reset", st_valid, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 tvalid after release", ob_n, 0);
    chk("R1 status after release", st_n, 0);
  endtask

  task automatic t_unicast();
    run("R2/R5 exact unicast", UC, 0, 16'h0800, 64, 0, 1, 6'b000000);
    run("R5 masked bits differ", 48'h02_11_22_33_44_99, 0, 16'h0800, 72, 0, 1, 6'b000000);
    run("R5/R11 unicast mismatch", 48'h02_11_22_33_45_55, 0, 16'h0800, 64, 0, 0, 6'b010000);
  endtask

  task automatic t_fcs();
    run("R10 fcs error", UC, 0, 16'h0800, 100, 1, 1, 6'b001000);
  endtask

  task automatic t_bcast();
    run("R4 broadcast accepted", BC, 0, 16'h0800, 64, 0, 1, 6'b000000);
    @(negedge clk) cfg_bcast_reject = 1;
    run("R4/R11 broadcast rejected", BC, 0, 16'h0800, 64, 0, 0, 6'b100000);
    @(negedge clk) cfg_bcast_reject = 0;
  endtask

  task automatic t_mcast();
    run("R6 multicast match", 48'h01_00_5E_7F_00_01, 0, 16'h0800, 64, 0, 1, 6'b000000);
    run("R6 multicast mismatch", 48'h01_00_5E_80_00_01, 0, 16'h0800, 64, 0, 0, 6'b010000);
  endtask

  task automatic t_oversize();
    @(negedge clk) cfg_mtu = 14'd100;
    run("R7 length equals mtu", UC, 0, 16'h0800, 100, 0, 1, 6'b000000);
    run("R7 one byte over mtu", UC, 0, 16'h0800, 101, 0, 1, 6'b000001);
    @(negedge clk) cfg_mtu = 14'd1518;
  endtask

  task automatic t_undersize();
    run("R8 60 byte frame", UC, 0, 16'h0800, 60, 0, 1, 6'b000010);
    run("R8 tagged 66 bytes", UC, 1, 16'h0800, 66, 0, 1, 6'b000010);
    run("R8 tagged 68 bytes", UC, 1, 16'h0800, 68, 0, 1, 6'b000000);
  endtask

  task automatic t_lenfield();
    run("R9 length 50 matches", UC, 0, 16'd50, 68, 0, 1, 6'b000000);
    run("R9 length 60 mismatch", UC, 0, 16'd60, 68, 0, 1, 6'b000100);
    run("R9 short length padded", UC, 0, 16'd20, 64, 0, 1, 6'b000000);
    run("R9 excess padding", UC, 0, 16'd20, 70, 0, 1, 6'b000100);
    run("R9 value 1501 unchecked", UC, 0, 16'd1501, 64, 0, 1, 6'b000000);
    run("R9 tagged length ok", UC, 1, 16'd50, 72, 0, 1, 6'b000000);
    run("R9 tagged length bad", UC, 1, 16'd51, 72, 0, 1, 6'b000100);
  endtask

  task automatic t_stray();
    clear_mon();
    for (int b = 0; b < 2; b++) begin
      @(negedge clk);
      in_valid = 1; in_sof = 0; in_eof = (b == 1); in_keep = 8'hFF;
      in_data = 64'hFFFF_FFFF_FFFF_FFFF;
    end
    @(negedge clk);
    idle_inputs();
    repeat (2) @(negedge clk);
    chk("R3 stray beats forwarded", ob_n, 0);
    chk("R3 stray beats status", st_n, 0);
    run("R3 frame after stray beats", UC, 0, 16'h0800, 64, 0, 1, 6'b000000);
  endtask

  task automatic t_filter_off();
    @(negedge clk) cfg_filter_en = 0;
    run("R5 filter disabled", 48'h02_99_22_33_45_55, 0, 16'h0800, 64, 0, 1, 6'b000000);
    @(negedge clk) cfg_filter_en = 1;
  endtask

  initial begin
    t_reset();
    t_unicast();
    t_fcs();
    t_bcast();
    t_mcast();
    t_oversize();
    t_undersize();
    t_lenfield();
    t_stray();
    t_filter_off();
    done = 1;
    $display("test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tot++;
      bad++;
      $display("FAIL R11 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", tot, bad);
      $finish;
    end
  end
endmodule